// File: doc/BRIEF.md
# Receive Frame Admission Controller

This block makes the keep-or-drop call for every received Ethernet frame. It watches the frame delimiters, the frame length and an optional verdict from an external address decoder. When a frame ends it gives a single-cycle decision: pass the frame to the host, or drop it. It also keeps a saturating count of frames that were lost only because the receiver was switched off.

Receiver enable is captured when a frame starts. Switching the receiver off in the middle of a frame does not cut that frame. Switching it on in the middle of a frame does not rescue that frame. Promiscuous mode bypasses the external decoder's verdict. The length rule still applies in promiscuous mode.

The external decoder reports its result through a valid strobe and a hit level. A polarity input sets whether a hit means "keep" or "drop". The result counts only if it arrives within a fixed window after the frame starts. A late result, or none at all, leaves the address test passing.

Top module: `rx_admit_ctrl`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `decide_valid_o`, `accept_o` and `miss_cnt_o` are all zero.
- R2: A frame opens with `sof_i`. The `eof_i` that closes it makes `decide_valid_o` high for exactly the following cycle. An `eof_i` when no frame is open produces no decision.
- R3: The length test passes for `frame_len_i` of 64 or more. For lengths 8 to 63 it passes only when `runt_ok_i` is 1. Below 8 it always fails. `accept_o` can be 1 only when the length test passes.
- R4: With `match_pol_i` = 1, an external hit (`ext_hit_i` = 1) passes the address test and a miss fails it. With `match_pol_i` = 0, a hit fails it and a miss passes it.
- R5: With `promisc_i` = 1, the address test passes whatever the external decoder reports.
- R6: Only the first `ext_valid_i` pulse counts. It must fall in frame cycles 1 to WIN, where cycle 1 is the cycle after `sof_i`, and must come before the `eof_i` cycle. Any later pulse, or a pulse on the `eof_i` cycle, is ignored. If no pulse counts, the address test passes.
- R7: `rx_en_i` is sampled on the `sof_i` cycle and held for that frame. `accept_o` = 1 exactly when the held enable, the length test and the address test are all 1.
- R8: `miss_cnt_o` increments by one when a frame ends with the held enable at 0 and both the length and address tests passing. It changes for no other frame.
- R9: `miss_cnt_o` stops at 255 and stays there until it is read.
- R10: A one-cycle `miss_rd_i` reads `miss_cnt_o`. On the next cycle the count is 0, or 1 if a counted miss ended on the read cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| promisc_i | input | 1 | Promiscuous mode: ignore the external verdict |
| match_pol_i | input | 1 | 1: a hit means keep; 0: a hit means drop |
| runt_ok_i | input | 1 | Keep frames of 8 to 63 bytes |
| rx_en_i | input | 1 | Receiver enable, sampled at frame start |
| sof_i | input | 1 | Frame start strobe |
| eof_i | input | 1 | Frame end strobe |
| frame_len_i | input | LEN_W | Frame length in bytes, valid with `eof_i` |
| ext_valid_i | input | 1 | External decoder result strobe |
| ext_hit_i | input | 1 | External decoder hit level |
| miss_rd_i | input | 1 | Read strobe; clears the missed count |
| decide_valid_o | output | 1 | Decision strobe, one per frame |
| accept_o | output | 1 | Pass the frame to the host |
| miss_cnt_o | output | CNT_W | Saturating missed-frame count |

## Verification
The assertions assume the following about the inputs:
- `sof_i` and `eof_i` are never high in the same cycle.
- `match_pol_i`, `promisc_i` and `runt_ok_i` stay stable inside a frame.
- `frame_len_i` is valid on the `eof_i` cycle.
- `miss_rd_i` is a single-cycle pulse.

The bench meets these assumptions directly. It changes the mode inputs only on the cycle that raises `sof_i`. It drives the length together with the end strobe. It raises the read strobe only in gaps between frames, and for one cycle.

// File: rtl/rx_adm_pkg.sv
package rx_adm_pkg;
   // Result of the two filters applied at frame end
   typedef struct packed {
      logic len_ok;
      logic addr_ok;
   } adm_verdict_t;

   // Address test: the polarity bit decides which pin level means keep
   function automatic logic addr_pass(input logic promisc, input logic pol,
                                      input logic seen, input logic hit);
      if (promisc || !seen) return 1'b1;
      return ~(hit ^ pol);
   endfunction
endpackage

// File: rtl/rx_adm_win.sv
module rx_adm_win #(
   parameter int WIN     = 16,
   parameter bit EXT_REG = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sof_i,
   input  logic eof_i,
   input  logic ext_valid_i,
   input  logic ext_hit_i,
   output logic in_frame_o,
   output logic seen_o,
   output logic hit_o
);
   localparam int CW = $clog2(WIN + 1);

   logic          ev, eh;
   logic [CW-1:0] cyc_q;
   logic          open_w;

   generate
      if (EXT_REG) begin : g_reg
         logic ev_q, eh_q;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               ev_q <= 1'b0;
               eh_q <= 1'b0;
            end else begin
               ev_q <= ext_valid_i;
               eh_q <= ext_hit_i;
            end
         end
         assign ev = ev_q;
         assign eh = eh_q;
      end else begin : g_dir
         assign ev = ext_valid_i;
         assign eh = ext_hit_i;
      end
   endgenerate

   assign open_w = in_frame_o && (cyc_q < CW'(WIN)) && !eof_i && !seen_o;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         in_frame_o <= 1'b0;
         cyc_q      <= '0;
         seen_o     <= 1'b0;
         hit_o      <= 1'b0;
      end else if (sof_i) begin
         in_frame_o <= 1'b1;
         cyc_q      <= '0;
         seen_o     <= 1'b0;
         hit_o      <= 1'b0;
      end else begin
         if (eof_i) in_frame_o <= 1'b0;
         if (in_frame_o && cyc_q < CW'(WIN)) cyc_q <= cyc_q + 1'b1;
         if (open_w && ev) begin
            seen_o <= 1'b1;
            hit_o  <= eh;
         end
      end
   end
endmodule

// File: rtl/rx_adm_judge.sv
module rx_adm_judge
   import rx_adm_pkg::*;
#(
   parameter int LEN_W    = 12,
   parameter int MIN_LEN  = 64,
   parameter int RUNT_MIN = 8
) (
   input  logic             promisc_i,
   input  logic             pol_i,
   input  logic             runt_ok_i,
   input  logic             en_i,
   input  logic             seen_i,
   input  logic             hit_i,
   input  logic [LEN_W-1:0] len_i,
   output logic             accept_o,
   output logic             missed_o
);
   adm_verdict_t v;

   always_comb begin
      v.len_ok  = (len_i >= LEN_W'(MIN_LEN)) ||
                  (runt_ok_i && (len_i >= LEN_W'(RUNT_MIN)));
      v.addr_ok = addr_pass(promisc_i, pol_i, seen_i, hit_i);
      accept_o  = en_i & v.len_ok & v.addr_ok;
      missed_o  = ~en_i & v.len_ok & v.addr_ok;
   end
endmodule

// File: rtl/rx_adm_mpc.sv
module rx_adm_mpc #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             inc_i,
   input  logic             clr_i,
   output logic [CNT_W-1:0] cnt_o
);
   localparam logic [CNT_W-1:0] TOP = '1;

   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt_o <= '0;
      else if (clr_i)
         cnt_o <= inc_i ? CNT_W'(1) : '0;
      else if (inc_i && cnt_o != TOP)
         cnt_o <= cnt_o + 1'b1;
   end
endmodule

// File: rtl/rx_admit_ctrl.sv
module rx_admit_ctrl #(
   parameter int LEN_W    = 12,
   parameter int CNT_W    = 8,
   parameter int WIN      = 16,
   parameter int MIN_LEN  = 64,
   parameter int RUNT_MIN = 8,
   parameter bit EXT_REG  = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             promisc_i,
   input  logic             match_pol_i,
   input  logic             runt_ok_i,
   input  logic             rx_en_i,
   input  logic             sof_i,
   input  logic             eof_i,
   input  logic [LEN_W-1:0] frame_len_i,
   input  logic             ext_valid_i,
   input  logic             ext_hit_i,
   input  logic             miss_rd_i,
   output logic             decide_valid_o,
   output logic             accept_o,
   output logic [CNT_W-1:0] miss_cnt_o
);
   generate
      if (WIN < 1) begin : g_bad_win
         $error("WIN must be at least 1");
      end
      if (RUNT_MIN > MIN_LEN || MIN_LEN >= (1 << LEN_W)) begin : g_bad_len
         $error("length limits do not fit LEN_W");
      end
   endgenerate

   logic in_frame, seen, hit, en_q, acc_w, miss_w, done_w;

   rx_adm_win #(.WIN(WIN), .EXT_REG(EXT_REG)) u_win (
      .clk(clk), .rst_n(rst_n), .sof_i(sof_i), .eof_i(eof_i),
      .ext_valid_i(ext_valid_i), .ext_hit_i(ext_hit_i),
      .in_frame_o(in_frame), .seen_o(seen), .hit_o(hit));

   rx_adm_judge #(.LEN_W(LEN_W), .MIN_LEN(MIN_LEN), .RUNT_MIN(RUNT_MIN)) u_judge (
      .promisc_i(promisc_i), .pol_i(match_pol_i), .runt_ok_i(runt_ok_i),
      .en_i(en_q), .seen_i(seen), .hit_i(hit), .len_i(frame_len_i),
      .accept_o(acc_w), .missed_o(miss_w));

   assign done_w = in_frame & eof_i & ~sof_i;

   rx_adm_mpc #(.CNT_W(CNT_W)) u_mpc (
      .clk(clk), .rst_n(rst_n), .inc_i(done_w & miss_w),
      .clr_i(miss_rd_i), .cnt_o(miss_cnt_o));

   // Enable is held per frame: it is captured only when a frame opens
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_q           <= 1'b0;
         decide_valid_o <= 1'b0;
         accept_o       <= 1'b0;
      end else begin
         if (sof_i) en_q <= rx_en_i;
         decide_valid_o <= done_w;
         accept_o       <= done_w & acc_w;
      end
   end
endmodule

// File: rtl/rx_admit_chk.sv
module rx_admit_chk #(
   parameter int LEN_W = 12,
   parameter int CNT_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             runt_ok_i,
   input logic             eof_i,
   input logic [LEN_W-1:0] frame_len_i,
   input logic             miss_rd_i,
   input logic             decide_valid_o,
   input logic             accept_o,
   input logic [CNT_W-1:0] miss_cnt_o
);
   localparam logic [CNT_W-1:0] TOP = '1;

   // R2
   decide_after_eof_chk: assert property (@(posedge clk) disable iff (!rst_n)
      decide_valid_o |-> $past(eof_i));

   // R2
   single_decide_chk: assert property (@(posedge clk) disable iff (!rst_n)
      decide_valid_o |=> !decide_valid_o);

   // R7
   accept_needs_decide_chk: assert property (@(posedge clk) disable iff (!rst_n)
      accept_o |-> decide_valid_o);

   // R3
   accept_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      accept_o |-> ($past(frame_len_i) >= LEN_W'(64)) ||
                   ($past(runt_ok_i) && $past(frame_len_i) >= LEN_W'(8)));

   // R8
   miss_only_on_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(miss_rd_i) && miss_cnt_o != $past(miss_cnt_o))
         |-> (decide_valid_o && !accept_o && miss_cnt_o == $past(miss_cnt_o) + 1'b1));

   // R9
   miss_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (miss_cnt_o == TOP && !miss_rd_i) |=> miss_cnt_o == TOP);

   // R10
   miss_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      miss_rd_i |=> miss_cnt_o <= CNT_W'(1));
endmodule

bind rx_admit_ctrl rx_admit_chk #(.LEN_W(LEN_W), .CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .runt_ok_i(runt_ok_i), .eof_i(eof_i),
   .frame_len_i(frame_len_i), .miss_rd_i(miss_rd_i),
   .decide_valid_o(decide_valid_o), .accept_o(accept_o),
   .miss_cnt_o(miss_cnt_o));

// File: tb/sim_rx_admit_ctrl.sv
`timescale 1ns/1ps
module sim_rx_admit_ctrl;
   localparam int LEN_W = 12;
   localparam int WIN   = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic promisc = 0, pol = 0, runt = 0, rx_en = 0, sof = 0, eof = 0;
   logic ext_v = 0, ext_h = 0, mrd = 0;
   logic [LEN_W-1:0] flen = '0;
   logic dv, acc;
   logic [7:0] mcnt;

   int errors = 0, checks = 0, exp_miss = 0;

   always #10 clk = ~clk;

   rx_admit_ctrl #(.LEN_W(LEN_W), .WIN(WIN)) u0 (
      .clk(clk), .rst_n(rst_n), .promisc_i(promisc), .match_pol_i(pol),
      .runt_ok_i(runt), .rx_en_i(rx_en), .sof_i(sof), .eof_i(eof),
      .frame_len_i(flen), .ext_valid_i(ext_v), .ext_hit_i(ext_h),
      .miss_rd_i(mrd), .decide_valid_o(dv), .accept_o(acc), .miss_cnt_o(mcnt));

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic bit len_pass(int len, bit r);
      return (len >= 64) || (r && len >= 8);
   endfunction

   function automatic bit addr_ok(bit p, bit po, bit seen, bit h);
      if (p || !seen) return 1'b1;
      return (h == po);
   endfunction

   // One frame: mode inputs set with sof, enable flipped to en_mid in cycle 1,
   // ext pulse in frame cycle ext_at (0: none), eof in frame cycle dur
   task automatic frame(input int len, input bit p, input bit po, input bit r,
                        input bit en, input bit en_mid, input int ext_at,
                        input bit h, input int dur, input string req);
      bit seen, a, l, exp_acc;
      @(negedge clk);
      promisc = p; pol = po; runt = r; rx_en = en; sof = 1;
      @(negedge clk);
      sof = 0;
      for (int k = 1; k <= dur; k++) begin
         ext_v = (k == ext_at); ext_h = h;
         if (k == 1) rx_en = en_mid;
         if (k == dur) begin eof = 1; flen = LEN_W'(len); end
         @(negedge clk);
      end
      eof = 0; ext_v = 0;
      seen = (ext_at >= 1) && (ext_at <= WIN) && (ext_at < dur);
      a = addr_ok(p, po, seen, h);
      l = len_pass(len, r);
      exp_acc = en && a && l;
      if (!en && a && l && exp_miss < 255) exp_miss++;
      chk({req, " decide strobe R2"}, dv, 1);
      chk({req, " accept"}, acc, exp_acc);
      chk({req, " miss count R8"}, mcnt, exp_miss);
   endtask

   task automatic read_miss();
      @(negedge clk);
      chk("R10 count before read", mcnt, exp_miss);
      mrd = 1;
      @(negedge clk);
      mrd = 0;
      chk("R10 count after read", mcnt, 0);
      exp_miss = 0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 reset decide", dv, 0);
      chk("R1 reset accept", acc, 0);
      chk("R1 reset count", mcnt, 0);
      rst_n = 1;
      @(negedge clk);
      chk("R1 after reset decide", dv, 0);
      chk("R1 after reset count", mcnt, 0);

      // R2: stray eof with no open frame
      eof = 1; flen = 100;
      @(negedge clk); eof = 0;
      @(negedge clk);
      chk("R2 stray eof", dv, 0);

      // R3 length boundaries
      frame(64, 1, 0, 0, 1, 1, 0, 0, 4, "R3 len64");
      frame(63, 1, 0, 0, 1, 1, 0, 0, 4, "R3 len63 no runt");
      frame(63, 1, 0, 1, 1, 1, 0, 0, 4, "R3 len63 runt");
      frame(8,  1, 0, 1, 1, 1, 0, 0, 4, "R3 len8 runt");
      frame(7,  1, 0, 1, 1, 1, 0, 0, 4, "R3 len7 runt");
      // R4 polarity
      frame(100, 0, 1, 0, 1, 1, 2, 1, 6, "R4 pol1 hit");
      frame(100, 0, 1, 0, 1, 1, 2, 0, 6, "R4 pol1 miss");
      frame(100, 0, 0, 0, 1, 1, 2, 1, 6, "R4 pol0 hit");
      frame(100, 0, 0, 0, 1, 1, 2, 0, 6, "R4 pol0 miss");
      // R5 promiscuous overrides reject
      frame(100, 1, 0, 0, 1, 1, 3, 1, 6, "R5 promisc reject");
      // R6 window edges
      frame(100, 0, 0, 0, 1, 1, WIN, 1, WIN + 4, "R6 last window cycle");
      frame(100, 0, 0, 0, 1, 1, WIN + 1, 1, WIN + 4, "R6 late pulse");
      frame(100, 0, 0, 0, 1, 1, 5, 1, 5, "R6 pulse on eof");
      frame(100, 0, 0, 0, 1, 1, 0, 0, 5, "R6 no pulse");
      // R7 enable captured at frame start
      frame(100, 1, 0, 0, 1, 0, 0, 0, 5, "R7 disable mid frame");
      frame(100, 1, 0, 0, 0, 1, 0, 0, 5, "R7 enable mid frame");
      // R8 filtered disabled frame not counted
      frame(20, 1, 0, 0, 0, 0, 0, 0, 3, "R8 disabled short");
      read_miss();

      // Random mix
      for (int i = 0; i < 400; i++) begin
         int len, ea, dur;
         len = int'($urandom_range(0, 200));
         dur = int'($urandom_range(2, 30));
         ea  = int'($urandom_range(0, 24));
         frame(len, 1'($urandom_range(0, 3) == 0), 1'($urandom),
               1'($urandom), 1'($urandom), 1'($urandom), ea,
               1'($urandom), dur, "R7 random");
         if (i % 97 == 50) read_miss();
      end

      // R9 saturation
      read_miss();
      for (int i = 0; i < 260; i++)
         frame(100, 1, 0, 0, 0, 0, 0, 0, 2, "R9 saturate");
      chk("R9 saturated value", mcnt, 255);
      read_miss();

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      void'($urandom(32'd1234));
      repeat (150000) @(posedge clk);
      errors++; checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule